// File: doc/BRIEF.md
# Streaming Field CRC-8 Checker

This block computes an 8-bit CRC one bit at a time while a framed serial response arrives from a position sensor, so the result is ready when the last bit is sampled and nothing remains to be computed afterwards. A frame is made of 10-bit fields. Each field opens with a low start bit, carries eight payload bits with the least significant bit first, and closes with a high delimiter bit. A bit-position counter inside the datapath tells the framing bits apart from payload bits, so only payload bits reach the shift register and no bytes are buffered.

In check mode the final field of the frame is the transmitted CRC. Its payload is gathered in place and compared with the computed value at its delimiter. In generate mode every field feeds the register, so the same core can produce the CRC for an outgoing request. A line-timing front end supplies the sample strobe, and a synchronous clear restarts the block at the start of each receive phase.

Top module: `fcrc_rx_engine`

## Requirements
- R1: After reset, or in the cycle after `clr` is high, `crc_out` is 0 and `done`, `crc_match` and `frame_err` are all low.
- R2: The CRC starts at 0 and has no final inversion. For each payload bit b, with feedback f = crc[7] xor b, the next value is {crc[6:0],0} xor (f ? POLY : 0). The default POLY is 8'h01, which is x^8+1. Payload bits are taken in arrival order, least significant bit first.
- R3: Start bits (position 0 of a field) and delimiter bits (position 9) leave `crc_out` unchanged.
- R4: A strobe while `rx_en` is low has no effect: it moves neither the CRC nor the bit position.
- R5: In check mode (`gen_mode`=0), field `num_fields`-1 (fields counted from 0) is not fed into the CRC. Its payload is captured least significant bit first. In the cycle after its delimiter strobe, `done` goes high and `crc_match` is 1 exactly when the captured byte equals `crc_out`.
- R6: In generate mode (`gen_mode`=1), the payload of all `num_fields` fields enters the CRC. `done` rises after the last delimiter, and `crc_match` stays 0.
- R7: A start bit of 1 or a delimiter bit of 0 sets `frame_err` in the following cycle. The flag stays set until reset or clear, and reception continues.
- R8: While `done` is high, strobes change none of `crc_out`, `done` or `crc_match` until `clr`.
- R9: `clr` takes priority over a strobe in the same cycle, and the next frame starts at field 0, bit position 0.
- R10: `crc_out` is registered. It shows the effect of a payload strobe in the cycle after that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous restart at the start of a receive phase |
| rx_en | input | 1 | Receive phase active; strobes are ignored when low |
| bit_stb | input | 1 | One-cycle sample strobe for each serial bit |
| bit_in | input | 1 | Serial data bit sampled on the strobe |
| gen_mode | input | 1 | 1: all fields feed the CRC; 0: the last field is the CRC to check |
| num_fields | input | 5 | Number of fields in the frame, including the CRC field in check mode |
| crc_out | output | 8 | Running CRC |
| done | output | 1 | Frame complete |
| crc_match | output | 1 | Received CRC field equals the computed CRC |
| frame_err | output | 1 | Sticky start/delimiter violation |

## Verification
Random payloads over frame lengths from 2 to 16 fields, each ending in a correct CRC field, show that the payload bits are folded in the right order. The same frames with one bit of the CRC field flipped show that the comparison really depends on the captured byte. Strobes inserted while the receive phase is off, a clear that lands on a strobe, and extra strobes after completion show which events the block must ignore. Frames with a bad start bit and frames with a bad delimiter show that framing errors are caught without stopping reception. Generate-mode frames show that the final field is folded in rather than compared.

// File: rtl/fcrc_pkg.sv
package fcrc_pkg;
  typedef enum logic [1:0] {
    ROLE_START = 2'd0,
    ROLE_DATA  = 2'd1,
    ROLE_DELIM = 2'd2
  } bit_role_e;
endpackage

// File: rtl/fcrc_framer.sv
module fcrc_framer
  import fcrc_pkg::*;
#(
  parameter int W  = 8,
  parameter int FW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic [FW-1:0] num_fields,
  output bit_role_e     role,
  output logic          last_fld
);
  localparam int LAST = W + 1;
  localparam int PW   = $clog2(W + 2);

  logic [PW-1:0] pos;
  logic [FW-1:0] fld;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pos <= '0;
      fld <= '0;
    end else if (adv) begin
      if (pos == PW'(LAST)) begin
        pos <= '0;
        fld <= fld + 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  always_comb begin
    if (pos == '0)               role = ROLE_START;
    else if (pos == PW'(LAST))   role = ROLE_DELIM;
    else                         role = ROLE_DATA;
  end

  assign last_fld = (fld == (num_fields - FW'(1)));
endmodule

// File: rtl/fcrc_lfsr.sv
module fcrc_lfsr #(
  parameter int         W    = 8,
  parameter logic [W-1:0] POLY = 8'h01,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc_q
);
  logic         fb;
  logic [W-1:0] nxt;

  assign fb = crc_q[W-1] ^ din;

  for (genvar g = 0; g < W; g++) begin : g_tap
    if (g == 0) begin : g_lsb
      assign nxt[g] = POLY[g] & fb;
    end else begin : g_up
      assign nxt[g] = crc_q[g-1] ^ (POLY[g] & fb);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  crc_q <= INIT;
    else if (en)     crc_q <= nxt;
  end
endmodule

// File: rtl/fcrc_cmp.sv
module fcrc_cmp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         cap_en,
  input  logic         din,
  input  logic         fin,
  input  logic         gen_mode,
  input  logic         err_hit,
  input  logic [W-1:0] crc_q,
  output logic         done_q,
  output logic         match_q,
  output logic         err_q
);
  logic [W-1:0] rx_crc;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rx_crc  <= '0;
      done_q  <= 1'b0;
      match_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (cap_en) rx_crc <= {din, rx_crc[W-1:1]};
      if (fin) begin
        done_q  <= 1'b1;
        match_q <= !gen_mode && (rx_crc == crc_q);
      end
      if (err_hit) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/fcrc_rx_engine.sv
module fcrc_rx_engine
  import fcrc_pkg::*;
#(
  parameter int           W          = 8,
  parameter logic [W-1:0] POLY       = 8'h01,
  parameter int           MAX_FIELDS = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             clr,
  input  logic                             rx_en,
  input  logic                             bit_stb,
  input  logic                             bit_in,
  input  logic                             gen_mode,
  input  logic [$clog2(MAX_FIELDS+1)-1:0]  num_fields,
  output logic [W-1:0]                     crc_out,
  output logic                             done,
  output logic                             crc_match,
  output logic                             frame_err
);
  localparam int FW = $clog2(MAX_FIELDS + 1);

  bit_role_e role;
  logic      last_fld, adv, is_data, crc_fld, lfsr_en, cap_en, fin, err_hit;

  assign adv     = rx_en && bit_stb && !done && !clr;
  assign is_data = (role == ROLE_DATA);
  assign crc_fld = last_fld && !gen_mode;
  assign lfsr_en = adv && is_data && !crc_fld;
  assign cap_en  = adv && is_data && crc_fld;
  assign fin     = adv && (role == ROLE_DELIM) && last_fld;
  assign err_hit = adv && (((role == ROLE_START) && bit_in) ||
                           ((role == ROLE_DELIM) && !bit_in));

  fcrc_framer #(.W(W), .FW(FW)) u_frm (
    .clk(clk), .rst(rst), .clr(clr), .adv(adv),
    .num_fields(num_fields), .role(role), .last_fld(last_fld)
  );

  fcrc_lfsr #(.W(W), .POLY(POLY), .INIT('0)) u_lfsr (
    .clk(clk), .rst(rst), .clr(clr), .en(lfsr_en),
    .din(bit_in), .crc_q(crc_out)
  );

  fcrc_cmp #(.W(W)) u_cmp (
    .clk(clk), .rst(rst), .clr(clr), .cap_en(cap_en), .din(bit_in),
    .fin(fin), .gen_mode(gen_mode), .err_hit(err_hit), .crc_q(crc_out),
    .done_q(done), .match_q(crc_match), .err_q(frame_err)
  );
endmodule

// File: rtl/fcrc_rx_engine_chk.sv
module fcrc_rx_engine_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         clr,
  input logic         rx_en,
  input logic         bit_stb,
  input logic         gen_mode,
  input logic [W-1:0] crc_out,
  input logic         done,
  input logic         crc_match,
  input logic         frame_err
);
  localparam int PW   = $clog2(W + 2);
  localparam int LAST = W + 1;

  logic [PW-1:0] cpos;
  logic          cadv;
  assign cadv = rx_en && bit_stb && !done && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr)  cpos <= '0;
    else if (cadv)   cpos <= (cpos == PW'(LAST)) ? '0 : cpos + 1'b1;
  end

  p_clear_r1: assert property (@(posedge clk) disable iff (rst)
    clr |=> (crc_out == '0) && !done && !crc_match && !frame_err);

  p_skip_r3: assert property (@(posedge clk) disable iff (rst)
    (cadv && (cpos == '0 || cpos == PW'(LAST))) |=> $stable(crc_out));

  p_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !clr) |=> $stable(crc_out));

  p_match_done_r5: assert property (@(posedge clk) disable iff (rst)
    crc_match |-> done);

  p_gen_nomatch_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(done) && gen_mode) |-> !crc_match);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (frame_err && !clr) |=> frame_err);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !clr) |=> done && $stable(crc_out) && $stable(crc_match));
endmodule

bind fcrc_rx_engine fcrc_rx_engine_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .rx_en(rx_en), .bit_stb(bit_stb),
  .gen_mode(gen_mode), .crc_out(crc_out), .done(done),
  .crc_match(crc_match), .frame_err(frame_err)
);

// File: tb/fcrc_rx_engine_tb.sv
module fcrc_rx_engine_tb;
  localparam logic [7:0] POLY = 8'h01;

  logic       clk = 1'b0;
  logic       rst, clr, rx_en, bit_stb, bit_in, gen_mode;
  logic [4:0] num_fields;
  logic [7:0] crc_out;
  logic       done, crc_match, frame_err;

  int total = 0;
  int bad   = 0;
  logic [7:0] fld_d [16];

  always #4 clk = ~clk;

  fcrc_rx_engine u_dut (
    .clk(clk), .rst(rst), .clr(clr), .rx_en(rx_en), .bit_stb(bit_stb),
    .bit_in(bit_in), .gen_mode(gen_mode), .num_fields(num_fields),
    .crc_out(crc_out), .done(done), .crc_match(crc_match), .frame_err(frame_err)
  );

  function automatic logic [7:0] crc_bit(logic [7:0] c, logic b);
    logic       f;
    logic [7:0] r;
    f = c[7] ^ b;
    r = {c[6:0], 1'b0};
    if (f) r = r ^ POLY;
    return r;
  endfunction

  function automatic logic [7:0] crc_of(int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) c = crc_bit(c, fld_d[i][k]);
    return c;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(logic b);
    @(negedge clk);
    bit_in  = b;
    bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
    repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic noise(int n);
    @(negedge clk);
    rx_en = 1'b0;
    for (int i = 0; i < n; i++) strobe(1'($urandom_range(0, 1)));
    rx_en = 1'b1;
  endtask

  // Sends one field; the CRC must hold across start and delimiter (R3).
  task automatic send_field(logic [7:0] d, logic sb, logic db);
    logic [7:0] c;
    c = crc_out;
    strobe(sb);
    chk("R3 start", crc_out, c);
    for (int k = 0; k < 8; k++) strobe(d[k]);
    c = crc_out;
    strobe(db);
    chk("R3 delim", crc_out, c);
  endtask

  // Builds random payload, sends frame, checks result.
  task automatic run_frame(int n, logic gm, logic [7:0] flip, int noisy);
    logic [7:0] exp;
    for (int i = 0; i < n; i++) fld_d[i] = 8'($urandom);
    exp = gm ? crc_of(n) : crc_of(n - 1);
    if (!gm) fld_d[n-1] = exp ^ flip;
    pulse_clr();
    gen_mode   = gm;
    num_fields = 5'(n);
    rx_en      = 1'b1;
    for (int i = 0; i < n; i++) begin
      send_field(fld_d[i], 1'b0, 1'b1);
      if (noisy != 0 && i == 0) noise(noisy);
    end
    @(negedge clk);
    if (gm) begin
      chk("R6 crc", crc_out, exp);
      chk("R6 done", done, 1);
      chk("R6 match low", crc_match, 0);
    end else begin
      chk(noisy != 0 ? "R4 crc after ignored strobes" : "R2 crc", crc_out, exp);
      chk("R5 done", done, 1);
      chk("R5 match", crc_match, (flip == 0));
    end
    chk("R7 no err", frame_err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] c0;
    logic       m0;
    void'($urandom(32'd1234));
    rst = 1'b1; clr = 1'b0; rx_en = 1'b0; bit_stb = 1'b0; bit_in = 1'b0;
    gen_mode = 1'b0; num_fields = 5'd3;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 crc", crc_out, 0);
    chk("R1 flags", {done, crc_match, frame_err}, 0);

    // R10: one payload bit of 1 from zero gives POLY on the next cycle
    rx_en = 1'b1;
    strobe(1'b0);
    @(negedge clk); bit_in = 1'b1; bit_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0;
    chk("R10 registered update", crc_out, crc_bit(8'h00, 1'b1));

    // R9: clear coinciding with a strobe wins; next frame from field 0
    @(negedge clk); clr = 1'b1; bit_stb = 1'b1; bit_in = 1'b1;
    @(negedge clk); clr = 1'b0; bit_stb = 1'b0;
    chk("R9 crc cleared", crc_out, 0);
    chk("R1 err cleared", frame_err, 0);
    fld_d[0] = 8'hA5; fld_d[1] = 8'h3C;
    fld_d[2] = crc_of(2);
    for (int i = 0; i < 3; i++) send_field(fld_d[i], 1'b0, 1'b1);
    @(negedge clk);
    chk("R9 restart frame match", crc_match, 1);
    chk("R9 restart frame crc", crc_out, crc_of(2));

    // R8: strobes after completion are ignored
    c0 = crc_out; m0 = crc_match;
    for (int k = 0; k < 12; k++) strobe(1'($urandom_range(0, 1)));
    chk("R8 crc held", crc_out, c0);
    chk("R8 done held", done, 1);
    chk("R8 match held", crc_match, m0);

    // R2/R5 random check-mode frames, good and corrupted
    for (int t = 0; t < 12; t++) run_frame($urandom_range(2, 16), 1'b0, 8'h00, 0);
    for (int t = 0; t < 8; t++)
      run_frame($urandom_range(2, 16), 1'b0, 8'(1 << $urandom_range(0, 7)), 0);
    run_frame(11, 1'b0, 8'h00, 0);
    run_frame(2, 1'b0, 8'h80, 0);

    // R4 strobes with receive phase off
    run_frame(5, 1'b0, 8'h00, 7);

    // R6 generate mode
    for (int t = 0; t < 6; t++) run_frame($urandom_range(1, 16), 1'b1, 8'h00, 0);

    // R7 bad start bit, then bad delimiter
    pulse_clr();
    gen_mode = 1'b0; num_fields = 5'd3;
    send_field(8'h11, 1'b0, 1'b1);
    send_field(8'h22, 1'b1, 1'b1);
    chk("R7 bad start", frame_err, 1);
    send_field(8'h33, 1'b0, 1'b1);
    @(negedge clk);
    chk("R7 sticky, frame still ends", {frame_err, done}, 2'b11);
    pulse_clr();
    send_field(8'h44, 1'b0, 1'b0);
    chk("R7 bad delimiter", frame_err, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule